// File: doc/BRIEF.md
# Alias-Aware Instruction-Cache Line Invalidate Sequencer

This block turns one invalidate request into the stream of commands that a virtually indexed, physically tagged instruction cache needs in order to drop every copy of a physical range. When a cache way is larger than a page, a physical line can sit at several set indices. The number of such places is fixed at elaboration from the cache size, the way count and the page shift. Without a virtual address the block hits every candidate index of every line. With a virtual address it hits only the exact index. A whole-cache request produces a single flush command followed by a status read.

Two command encodings are supported, and an input chosen at request time selects between them. The packed encoding places the virtual index bits in the otherwise unused line-offset bits of the command address. The split encoding first sends the physical address as a tag command and then sends index commands. Commands leave one per cycle on a valid/ready port, and a one-cycle done pulse closes each request.

Top module: `vipt_icinv_engine`

## Requirements
- R1: The alias count is way size divided by page size, taken as 1 when that ratio is 0 or 1. Ratios of 2 and 4 are accepted, and any other ratio stops elaboration. Without a virtual address, each line produces exactly alias-count invalidate commands.
- R2: The range start is aligned down to a line boundary. The line count is ceil((len + start offset within line) / line bytes), and a length of 0 gives zero lines.
- R3: Packed encoding without a virtual address (req_kind=0, legacy_mode=1): for each line in ascending order, the block issues invalidates (cmd_kind=0) whose address is the line address with low bits 0,1,…,alias-count-1, in that order.
- R4: Packed encoding with a virtual address (req_kind=1, legacy_mode=1): for each line, the block issues one invalidate whose address is the line address with bits 4:0 replaced by virtual address bits 17:13.
- R5: Split encoding without a virtual address (req_kind=0, legacy_mode=0): for each line, the block issues a tag command (cmd_kind=1) carrying the line address. It then issues invalidates whose address is the line address with the log2(alias-count) bits at the page shift forced to 0,1,… in ascending order.
- R6: Split encoding with a virtual address (req_kind=1, legacy_mode=0): for each line i, the block issues a tag command with the physical line address. It then issues one invalidate with the line-aligned virtual address plus i line lengths.
- R7: req_kind=2 or 3 issues a whole-cache invalidate (cmd_kind=2, address 0) followed by a status read (cmd_kind=3, address 0). Done follows acceptance of the status read.
- R8: While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_kind and cmd_addr hold their values.
- R9: done is high for exactly one cycle, in the cycle after the last command is accepted, or in the cycle after acceptance for a zero-line request. req_ready is high only while idle, and never together with cmd_valid.
- R10: legacy_mode is sampled when the request is accepted. Changing it during a request does not affect that request's commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_kind | input | 2 | 0 range, 1 range with virtual address, 2/3 whole cache |
| req_paddr | input | ADDR_W | Physical start address |
| req_vaddr | input | ADDR_W | Virtual start address (kind 1) |
| req_len | input | LEN_W | Range length in bytes |
| legacy_mode | input | 1 | 1 packed encoding, 0 split tag/index encoding |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command taken by the cache |
| cmd_kind | output | 2 | 0 index invalidate, 1 tag, 2 whole-cache invalidate, 3 status read |
| cmd_addr | output | ADDR_W | Command address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a stall on the last alias command of the last line. That command moves the line pointer, the alias counter and the remaining-line count at the same time, and it decides whether done follows. The stimulus sweeps start offsets and lengths so that ranges end both exactly on and just past line boundaries. A fixed, irregular ready pattern then lands stalls on every position of the sequence in turn. A mid-request flip of the encoding input shows that the first command and every later one keep the latched encoding.

// File: rtl/vipt_icinv_pkg.sv
package vipt_icinv_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_TAG, ST_INV, ST_ALL, ST_STAT, ST_DONE
   } seq_state_t;

   localparam logic [1:0] CMD_IDX_INV = 2'd0;
   localparam logic [1:0] CMD_TAG     = 2'd1;
   localparam logic [1:0] CMD_ALL_INV = 2'd2;
   localparam logic [1:0] CMD_STATUS  = 2'd3;
endpackage

// File: rtl/vipt_icinv_range.sv
module vipt_icinv_range #(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 16,
   parameter int LINE_SH = 5,
   localparam int CNT_W  = LEN_W + 2 - LINE_SH
) (
   input  logic [ADDR_W-1:0] paddr,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [LEN_W-1:0]  len,
   output logic [ADDR_W-1:0] p_start,
   output logic [ADDR_W-1:0] v_start,
   output logic [CNT_W-1:0]  n_lines
);
   localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((1 << LINE_SH) - 1);
   localparam logic [LEN_W+1:0]  ROUND    = (LEN_W+2)'((1 << LINE_SH) - 1);

   logic [LEN_W+1:0] span;

   always_comb begin
      p_start = paddr & ~OFS_MASK;
      v_start = vaddr & ~OFS_MASK;
      span    = (LEN_W+2)'(len) + (LEN_W+2)'(paddr & OFS_MASK) + ROUND;
      n_lines = span[LEN_W+1:LINE_SH];
   end
endmodule

// File: rtl/vipt_icinv_fmt.sv
module vipt_icinv_fmt #(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 13,
   parameter int ALIAS_BITS = 2,
   parameter int LEG_W      = 5,
   localparam int IDX_W     = (ALIAS_BITS > 0) ? ALIAS_BITS : 1
) (
   input  logic              legacy,
   input  logic              use_va,
   input  logic [ADDR_W-1:0] line_addr,
   input  logic [ADDR_W-1:0] vline_addr,
   input  logic [LEG_W-1:0]  leg_bits,
   input  logic [IDX_W-1:0]  alias_idx,
   output logic [ADDR_W-1:0] inv_addr
);
   logic [ADDR_W-1:0] forced_addr;
   logic [ADDR_W-1:0] packed_addr;

   generate
      if (ALIAS_BITS == 0) begin : g_no_alias
         assign forced_addr = line_addr;
         assign packed_addr = line_addr;
      end else begin : g_alias
         localparam logic [ADDR_W-1:0] PG_MASK =
            ADDR_W'(((1 << ALIAS_BITS) - 1)) << PAGE_SHIFT;
         assign forced_addr = (line_addr & ~PG_MASK) |
                              (ADDR_W'(alias_idx) << PAGE_SHIFT);
         assign packed_addr = line_addr | ADDR_W'(alias_idx);
      end
   endgenerate

   always_comb begin
      if (legacy)
         inv_addr = use_va ? (line_addr | ADDR_W'(leg_bits)) : packed_addr;
      else
         inv_addr = use_va ? vline_addr : forced_addr;
   end
endmodule

// File: rtl/vipt_icinv_engine.sv
module vipt_icinv_engine #(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 16,
   parameter int CACHE_BYTES = 65536,
   parameter int WAYS        = 2,
   parameter int LINE_BYTES  = 32,
   parameter int PAGE_SHIFT  = 13,
   parameter int LEG_VA_LO   = 13,
   parameter int LEG_W       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_paddr,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              legacy_mode,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [1:0]        cmd_kind,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              done
);
   import vipt_icinv_pkg::*;

   localparam int WAY_BYTES  = CACHE_BYTES / WAYS;
   localparam int RATIO      = WAY_BYTES >> PAGE_SHIFT;
   localparam int N_ALIAS    = (RATIO <= 1) ? 1 : RATIO;
   localparam int ALIAS_BITS = $clog2(N_ALIAS);
   localparam int IDX_W      = (ALIAS_BITS > 0) ? ALIAS_BITS : 1;
   localparam int LINE_SH    = $clog2(LINE_BYTES);
   localparam int CNT_W      = LEN_W + 2 - LINE_SH;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ALIAS - 1);

   generate
      if (!(RATIO <= 1 || RATIO == 2 || RATIO == 4)) begin : g_bad_ratio
         $error("way-to-page ratio not supported");
      end
      if ((1 << LINE_SH) != LINE_BYTES) begin : g_bad_line
         $error("line length must be a power of two");
      end
      if (LINE_SH < LEG_W) begin : g_bad_leg
         $error("line offset too narrow for packed index bits");
      end
      if (PAGE_SHIFT + ALIAS_BITS > ADDR_W || LEG_VA_LO + LEG_W > ADDR_W) begin : g_bad_aw
         $error("address width too small");
      end
   endgenerate

   seq_state_t        state_q;
   logic [ADDR_W-1:0] line_q, vline_q;
   logic [CNT_W-1:0]  left_q;
   logic [IDX_W-1:0]  aidx_q;
   logic              useva_q, legacy_q;
   logic [LEG_W-1:0]  legbits_q;

   logic [ADDR_W-1:0] rng_pstart, rng_vstart, inv_addr;
   logic [CNT_W-1:0]  rng_cnt;
   logic              fire, last_alias;

   vipt_icinv_range #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_SH(LINE_SH)) range_i (
      .paddr   (req_paddr),
      .vaddr   (req_vaddr),
      .len     (req_len),
      .p_start (rng_pstart),
      .v_start (rng_vstart),
      .n_lines (rng_cnt)
   );

   vipt_icinv_fmt #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
                    .ALIAS_BITS(ALIAS_BITS), .LEG_W(LEG_W)) fmt_i (
      .legacy     (legacy_q),
      .use_va     (useva_q),
      .line_addr  (line_q),
      .vline_addr (vline_q),
      .leg_bits   (legbits_q),
      .alias_idx  (aidx_q),
      .inv_addr   (inv_addr)
   );

   assign req_ready  = (state_q == ST_IDLE);
   assign done       = (state_q == ST_DONE);
   assign cmd_valid  = (state_q == ST_TAG) || (state_q == ST_INV) ||
                       (state_q == ST_ALL) || (state_q == ST_STAT);
   assign fire       = cmd_valid && cmd_ready;
   assign last_alias = useva_q || (aidx_q == LAST_IDX);

   always_comb begin
      unique case (state_q)
         ST_TAG:  begin cmd_kind = CMD_TAG;     cmd_addr = line_q;   end
         ST_INV:  begin cmd_kind = CMD_IDX_INV; cmd_addr = inv_addr; end
         ST_ALL:  begin cmd_kind = CMD_ALL_INV; cmd_addr = '0;       end
         ST_STAT: begin cmd_kind = CMD_STATUS;  cmd_addr = '0;       end
         default: begin cmd_kind = CMD_IDX_INV; cmd_addr = '0;       end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         line_q    <= '0;
         vline_q   <= '0;
         left_q    <= '0;
         aidx_q    <= '0;
         useva_q   <= 1'b0;
         legacy_q  <= 1'b0;
         legbits_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               legacy_q  <= legacy_mode;
               useva_q   <= (req_kind == 2'd1);
               line_q    <= rng_pstart;
               vline_q   <= rng_vstart;
               left_q    <= rng_cnt;
               aidx_q    <= '0;
               legbits_q <= req_vaddr[LEG_VA_LO +: LEG_W];
               if (req_kind[1])
                  state_q <= ST_ALL;
               else if (rng_cnt == '0)
                  state_q <= ST_DONE;
               else
                  state_q <= legacy_mode ? ST_INV : ST_TAG;
            end
            ST_TAG: if (fire) state_q <= ST_INV;
            ST_INV: if (fire) begin
               if (!last_alias) begin
                  aidx_q <= aidx_q + 1'b1;
               end else begin
                  aidx_q  <= '0;
                  line_q  <= line_q + ADDR_W'(LINE_BYTES);
                  vline_q <= vline_q + ADDR_W'(LINE_BYTES);
                  left_q  <= left_q - 1'b1;
                  if (left_q == CNT_W'(1))
                     state_q <= ST_DONE;
                  else
                     state_q <= legacy_q ? ST_INV : ST_TAG;
               end
            end
            ST_ALL:  if (fire) state_q <= ST_STAT;
            ST_STAT: if (fire) state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vipt_icinv_chk.sv
module vipt_icinv_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [1:0]        cmd_kind,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              done
);
   // R8
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_addr)));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && cmd_valid));

   // R7
   all_then_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_kind == 2'd2) |=> (cmd_valid && cmd_kind == 2'd3));

   // R7
   stat_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_kind == 2'd3) |=> done);

   // R5
   tag_then_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_kind == 2'd1) |=> (cmd_valid && cmd_kind == 2'd0));
endmodule

bind vipt_icinv_engine vipt_icinv_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_kind  (cmd_kind),
   .cmd_addr  (cmd_addr),
   .done      (done)
);

// File: tb/vipt_icinv_engine_tb_top.sv
module vipt_icinv_engine_tb_top;
   localparam int AW = 32;
   localparam int LW = 16;
   localparam int LINE = 32;
   localparam int NAL = 4;
   localparam int PS = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          req_valid = 1'b0, req_ready, legacy_mode = 1'b0;
   logic [1:0]    req_kind = '0;
   logic [AW-1:0] req_paddr = '0, req_vaddr = '0;
   logic [LW-1:0] req_len = '0;
   logic          cmd_valid, cmd_ready = 1'b0, done;
   logic [1:0]    cmd_kind;
   logic [AW-1:0] cmd_addr;

   vipt_icinv_engine dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_paddr(req_paddr), .req_vaddr(req_vaddr),
      .req_len(req_len), .legacy_mode(legacy_mode), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .done(done)
   );

   int n_chk = 0, n_fail = 0, stall_bad = 0;
   logic [AW-1:0] exp_a [0:255];
   logic [1:0]    exp_k [0:255];
   logic [AW-1:0] got_a [0:255];
   logic [1:0]    got_k [0:255];
   int exp_n, got_n, exp_lines;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] k, input logic [AW-1:0] a);
      if (exp_n < 256) begin exp_k[exp_n] = k; exp_a[exp_n] = a; end
      exp_n++;
   endtask

   task automatic build_exp(input bit leg, input int kind, input logic [AW-1:0] pa,
                            input logic [AW-1:0] va, input int len);
      logic [AW-1:0] start, vstart, line;
      int slack;
      exp_n = 0;
      slack = int'(pa % LINE);
      start = pa - AW'(slack);
      vstart = va & ~AW'(LINE - 1);
      exp_lines = (len + slack + LINE - 1) / LINE;
      if (kind >= 2) begin
         push(2'd2, '0); push(2'd3, '0); exp_lines = 0;
      end else begin
         for (int i = 0; i < exp_lines; i++) begin
            line = start + AW'(i * LINE);
            if (leg) begin
               if (kind == 1) push(2'd0, line | ((va >> 13) & 32'h1F));
               else for (int a = 0; a < NAL; a++) push(2'd0, line | AW'(a));
            end else begin
               push(2'd1, line);
               if (kind == 1) push(2'd0, vstart + AW'(i * LINE));
               else for (int a = 0; a < NAL; a++)
                  push(2'd0, (line & ~(AW'(3) << PS)) | (AW'(a) << PS));
            end
         end
      end
   endtask

   task automatic run(input bit leg, input int kind, input logic [AW-1:0] pa,
                      input logic [AW-1:0] va, input int len, input bit flip, input string tag);
      int cyc;
      bit fin, held, ok, rdy;
      logic [AW-1:0] h_a;
      logic [1:0] h_k;
      int n_inv;
      build_exp(leg, kind, pa, va, len);
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'(kind); req_paddr = pa; req_vaddr = va;
      req_len = LW'(len); legacy_mode = leg;
      @(negedge clk);
      req_valid = 1'b0;
      if (flip) legacy_mode = ~leg;
      got_n = 0; cyc = 0; fin = 0; held = 0; h_a = '0; h_k = '0;
      while (!fin && cyc < 4000) begin
         if (done) fin = 1;
         else begin
            if (cmd_valid) begin
               if (held && (cmd_addr != h_a || cmd_kind != h_k)) stall_bad++;
               rdy = ((cyc * 7 + 3) % 5) != 0;
               cmd_ready = rdy;
               if (rdy) begin
                  if (got_n < 256) begin got_a[got_n] = cmd_addr; got_k[got_n] = cmd_kind; end
                  got_n++; held = 0;
               end else begin held = 1; h_a = cmd_addr; h_k = cmd_kind; end
            end else begin
               if (held) stall_bad++;
               cmd_ready = 1'b0;
            end
            @(negedge clk); cyc++;
         end
      end
      cmd_ready = 1'b0;
      chk(fin, "R9", "watchdog: done never seen", cyc, 0);
      // R2: command count follows the aligned line count
      chk(got_n == exp_n, "R2", {tag, " command count"}, got_n, exp_n);
      ok = (got_n == exp_n);
      for (int i = 0; i < exp_n && i < 256 && ok; i++)
         if (got_a[i] != exp_a[i] || got_k[i] != exp_k[i]) begin
            ok = 0;
            $display("FAIL %s entry %0d actual=%0d/%0h expected=%0d/%0h", tag, i,
                     got_k[i], got_a[i], exp_k[i], exp_a[i]);
         end
      n_chk++;
      if (!ok) n_fail++;
      if (kind == 0) begin
         n_inv = 0;
         for (int i = 0; i < got_n && i < 256; i++) if (got_k[i] == 2'd0) n_inv++;
         // R1: alias-count invalidates per line
         chk(n_inv == exp_lines * NAL, "R1", "invalidates per range", n_inv, exp_lines * NAL);
      end
      @(negedge clk);
      // R9: single-cycle done, back to idle
      chk(req_ready && !done && !cmd_valid, "R9", "idle after done", {done, req_ready}, 1);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL R9 global watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int lens[8];
      int offs[5];
      string tg;
      lens = '{0, 1, 31, 32, 33, 64, 100, 200};
      offs = '{0, 5, 31, 4095, 8189};
      repeat (3) @(negedge clk);
      chk(req_ready && !cmd_valid && !done, "R9", "reset state",
          {req_ready, cmd_valid, done}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      for (int leg = 0; leg < 2; leg++)
         for (int kind = 0; kind < 2; kind++)
            for (int o = 0; o < 5; o++)
               for (int l = 0; l < 8; l++) begin
                  if (leg == 1) tg = (kind == 0) ? "R3" : "R4";
                  else tg = (kind == 0) ? "R5" : "R6";
                  run(leg[0], kind, 32'h8000_6000 + AW'(offs[o]),
                      32'h0002_0000 + AW'((o * 8 + l) * 32'h2468), lens[l], 1'b0, tg);
               end
      // R7: whole-cache requests
      run(1'b0, 2, 32'h1234, 0, 10, 1'b0, "R7");
      run(1'b1, 3, 32'h0, 0, 0, 1'b0, "R7");
      // R10: encoding input flipped during the request
      run(1'b0, 0, 32'h8000_6010, 32'h0, 70, 1'b1, "R10");
      run(1'b1, 1, 32'h8000_6004, 32'h0003_A000, 90, 1'b1, "R10");
      // R8: stalled commands held steady
      chk(stall_bad == 0, "R8", "changes during stall", stall_bad, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule